// File: doc/BRIEF.md
# All-Ones Alarm Detector

This block watches a decoded receive bit stream and raises an alarm when the line carries an unbroken run of ones. That pattern is the usual indication that an upstream node has replaced real traffic with an alarm signal. An external strobe that repeats at a fixed rate cuts time into periods. The detector counts valid zero bits across a window of two consecutive strobe periods and makes a decision when each window closes. If too few zeros arrived, the alarm is set. If at least the threshold number arrived, the alarm is cleared. Between decisions the alarm output holds its value.

The strobe is level-sensitive at the pin, but only its rising edge counts. Holding it high for several cycles marks a single boundary. After reset the detector ignores the stream until the first boundary, so that the first window is always a whole one. Windows follow one another without overlap, and the zero count restarts at every window. The count saturates at the threshold, so the counter needs only two bits.

Top module: `ones_alarm_detect`

## Requirements
- R1: While `rst` is high at a rising clock edge, the detector is cleared. From the following cycle `alarm` is 0, the zero count is 0, and the detector is unarmed.
- R2: A period boundary is a cycle in which `strobe` is 1 and was 0 in the previous cycle. The first cycle after reset counts as having a previous value of 0. A `strobe` level held high for several cycles marks only one boundary.
- R3: The first boundary after reset only arms the detector and starts the first window. Zeros received before it are ignored, and that boundary makes no decision.
- R4: Once the detector is armed, windows are two consecutive strobe periods long and do not overlap. A decision is made at every second boundary after the arming boundary.
- R5: A zero is counted only in a cycle with `bit_vld` = 1 and `bit_in` = 0. A cycle with `bit_in` = 0 and `bit_vld` = 0 is not counted.
- R6: A zero received in the same cycle as a closing boundary counts toward the window that this boundary closes.
- R7: At a decision, `alarm` becomes 1 if the window held fewer than 3 zeros and 0 if it held 3 or more. The new value appears in the cycle after the boundary edge. `alarm` keeps its value in every other cycle.
- R8: The zero count saturates at 3 and does not wrap. A window with 4 or more zeros clears the alarm.
- R9: The zero count restarts at each decision, so zeros from one window never count toward the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Decoded receive data bit |
| bit_vld | input | 1 | Qualifier: `bit_in` is meaningful in this cycle |
| strobe | input | 1 | Periodic window strobe; its rising edge marks a period boundary |
| alarm | output | 1 | All-ones alarm, active high, held between decisions |

## Verification
The windows are driven with zero totals of zero, one, two, three and four. Two and three separate the two sides of the threshold. Four separates saturation from a two-bit wrap. Zeros are placed in either period of a window, which shows that the window spans both periods. One window ends with a zero in the closing boundary cycle, and another holds only unqualified zeros; these show which window an edge-cycle zero belongs to and that `bit_vld` gates the count. A burst of zeros before the first strobe, a strobe held high for three cycles in every period, a clear followed by a two-zero window, and a reset while the alarm is high test arming, edge detection, the count restart and the reset state.

// File: rtl/ones_alarm_pkg.sv
package ones_alarm_pkg;

    localparam int unsigned DEF_ZERO_THRESH = 3;
    localparam int unsigned DEF_WIN_PERIODS = 2;

    typedef struct packed {
        logic restart;
        logic close;
    } win_evt_t;

    function automatic int unsigned width_for(int unsigned maxval);
        return (maxval < 2) ? 1 : $clog2(maxval + 1);
    endfunction

endpackage

// File: rtl/oad_strobe_edge.sv
module oad_strobe_edge (
    input  logic clk,
    input  logic rst,
    input  logic strobe_i,
    output logic edge_o
);
    logic strobe_q;

    always_ff @(posedge clk) begin
        if (rst) strobe_q <= 1'b0;
        else     strobe_q <= strobe_i;
    end

    assign edge_o = strobe_i & ~strobe_q;
endmodule

// File: rtl/oad_window_seq.sv
module oad_window_seq
    import ones_alarm_pkg::*;
#(
    parameter int unsigned WIN_PERIODS = DEF_WIN_PERIODS
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     edge_i,
    output logic     armed_o,
    output win_evt_t evt_o
);
    localparam int unsigned PW = width_for(WIN_PERIODS - 1);

    logic armed_q;
    logic last_period;

    generate
        if (WIN_PERIODS == 1) begin : g_single
            assign last_period = 1'b1;
        end else begin : g_multi
            logic [PW-1:0] pcnt_q;
            assign last_period = (pcnt_q == PW'(WIN_PERIODS - 1));
            always_ff @(posedge clk) begin
                if (rst) begin
                    pcnt_q <= '0;
                end else if (edge_i) begin
                    if (!armed_q || last_period) pcnt_q <= '0;
                    else                         pcnt_q <= pcnt_q + 1'b1;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)         armed_q <= 1'b0;
        else if (edge_i) armed_q <= 1'b1;
    end

    always_comb begin
        evt_o.close   = edge_i & armed_q & last_period;
        evt_o.restart = edge_i & (~armed_q | last_period);
    end

    assign armed_o = armed_q;
endmodule

// File: rtl/oad_zero_count.sv
module oad_zero_count
    import ones_alarm_pkg::*;
#(
    parameter int unsigned ZERO_THRESH = DEF_ZERO_THRESH,
    localparam int unsigned ZW = width_for(ZERO_THRESH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          zero_i,
    input  logic          restart_i,
    output logic [ZW-1:0] count_o,
    output logic [ZW-1:0] total_o
);
    localparam logic [ZW-1:0] CAP = ZW'(ZERO_THRESH);

    logic [ZW-1:0] cnt_q;
    logic          at_cap;

    assign at_cap = (cnt_q == CAP);

    always_comb begin
        if (at_cap || !zero_i) total_o = cnt_q;
        else                   total_o = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)                  cnt_q <= '0;
        else if (restart_i)       cnt_q <= '0;
        else if (zero_i && !at_cap) cnt_q <= cnt_q + 1'b1;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/ones_alarm_detect.sv
module ones_alarm_detect
    import ones_alarm_pkg::*;
#(
    parameter int unsigned ZERO_THRESH = DEF_ZERO_THRESH,
    parameter int unsigned WIN_PERIODS = DEF_WIN_PERIODS
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    input  logic bit_vld,
    input  logic strobe,
    output logic alarm
);
    localparam int unsigned ZW = width_for(ZERO_THRESH);

    logic          bnd_edge;
    logic          armed;
    win_evt_t      win_evt;
    logic          zero_now;
    logic [ZW-1:0] zero_cnt;
    logic [ZW-1:0] zero_total;
    logic          alarm_q;

    oad_strobe_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .strobe_i (strobe),
        .edge_o   (bnd_edge)
    );

    oad_window_seq #(.WIN_PERIODS(WIN_PERIODS)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .edge_i  (bnd_edge),
        .armed_o (armed),
        .evt_o   (win_evt)
    );

    assign zero_now = bit_vld & ~bit_in & armed;

    oad_zero_count #(.ZERO_THRESH(ZERO_THRESH)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .zero_i    (zero_now),
        .restart_i (win_evt.restart),
        .count_o   (zero_cnt),
        .total_o   (zero_total)
    );

    always_ff @(posedge clk) begin
        if (rst)                alarm_q <= 1'b0;
        else if (win_evt.close) alarm_q <= (zero_total < ZW'(ZERO_THRESH));
    end

    assign alarm = alarm_q;
endmodule

// File: rtl/ones_alarm_chk.sv
module ones_alarm_chk #(
    parameter int unsigned ZERO_THRESH = 3,
    parameter int unsigned ZW = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          strobe,
    input logic          alarm,
    input logic          close,
    input logic [ZW-1:0] total,
    input logic [ZW-1:0] zcount
);
    a_r1_reset_clears: assert property (@(posedge clk) rst |=> (!alarm && zcount == '0));

    a_r2_close_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        close |-> strobe);

    a_r4_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        close |=> !close);

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !close |=> $stable(alarm));

    a_r7_set: assert property (@(posedge clk) disable iff (rst)
        (close && total < ZW'(ZERO_THRESH)) |=> alarm);

    a_r8_clear_at_cap: assert property (@(posedge clk) disable iff (rst)
        (close && total == ZW'(ZERO_THRESH)) |=> !alarm);

    a_r9_restart: assert property (@(posedge clk) disable iff (rst)
        close |=> (zcount == '0));
endmodule

bind ones_alarm_detect ones_alarm_chk #(
    .ZERO_THRESH (ZERO_THRESH),
    .ZW          (ZW)
) chk_i (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .alarm  (alarm),
    .close  (win_evt.close),
    .total  (zero_total),
    .zcount (zero_cnt)
);

// File: tb/ones_alarm_detect_tb_top.sv
`timescale 1ns/100ps
module ones_alarm_detect_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_in = 1'b1;
    logic bit_vld = 1'b0;
    logic strobe = 1'b0;
    logic alarm;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // reference model state
    int  m_armed = 0;
    int  m_periods = 0;
    int  m_zeros = 0;
    bit  m_prev_strobe = 1'b0;
    bit  m_alarm = 1'b0;

    always #2.5 clk = ~clk;

    ones_alarm_detect dut_i (
        .clk     (clk),
        .rst     (rst),
        .bit_in  (bit_in),
        .bit_vld (bit_vld),
        .strobe  (strobe),
        .alarm   (alarm)
    );

    task automatic model_clock(bit r, bit v, bit d, bit s);
        bit edge_seen;
        bit zero_seen;
        if (r) begin
            m_armed = 0; m_periods = 0; m_zeros = 0;
            m_prev_strobe = 1'b0; m_alarm = 1'b0;
            return;
        end
        edge_seen = s && !m_prev_strobe;
        zero_seen = v && !d;
        if (m_armed != 0 && zero_seen) m_zeros++;
        if (edge_seen) begin
            if (m_armed == 0) begin
                m_armed = 1; m_periods = 0; m_zeros = 0;
            end else begin
                m_periods++;
                if (m_periods == 2) begin
                    m_alarm = (m_zeros < 3);
                    m_zeros = 0;
                    m_periods = 0;
                end
            end
        end
        m_prev_strobe = s;
    endtask

    task automatic step(bit r, bit v, bit d, bit s, string tag);
        @(negedge clk);
        vectors++;
        if (alarm !== m_alarm) begin
            miscompares++;
            $display("FAIL %s: alarm actual %b expected %b at %0t", tag, alarm, m_alarm, $time);
        end
        rst = r; bit_vld = v; bit_in = d; strobe = s;
        @(posedge clk);
        model_clock(r, v, d, s);
    endtask

    task automatic expect_alarm(bit exp, string tag);
        #1;
        vectors++;
        if (alarm !== exp) begin
            miscompares++;
            $display("FAIL %s: alarm actual %b expected %b", tag, alarm, exp);
        end
    endtask

    // strobe high for the first three cycles (R2: one boundary per period)
    task automatic period(int zeros, bit unqualified, bit edge_zero, string tag);
        for (int c = 0; c < 10; c++) begin
            bit s = (c < 3);
            bit d = 1'b1;
            bit v = 1'b1;
            if (c == 0 && edge_zero) d = 1'b0;
            if (c >= 4 && c < 4 + zeros) begin
                d = 1'b0;
                v = !unqualified;
            end
            step(1'b0, v, d, s, tag);
        end
    endtask

    initial begin
        step(1'b1, 1'b0, 1'b1, 1'b0, "R1");
        step(1'b1, 1'b0, 1'b1, 1'b0, "R1");
        expect_alarm(1'b0, "R1 reset state");
        // zeros before the arming boundary are ignored (R3)
        for (int i = 0; i < 12; i++) step(1'b0, 1'b1, 1'b0, 1'b0, "R3");
        // W1: 0 + 1 zeros -> set
        period(0, 1'b0, 1'b0, "R3");
        period(1, 1'b0, 1'b0, "R2");
        // W2: 2 + 1 zeros -> clear
        period(2, 1'b0, 1'b0, "R7");
        expect_alarm(1'b1, "R7 set after one-zero window (R3 arming)");
        period(1, 1'b0, 1'b0, "R4");
        // W3: no zeros -> set
        period(0, 1'b0, 1'b0, "R7");
        expect_alarm(1'b0, "R4 zeros in both periods clear");
        period(0, 1'b0, 1'b0, "R7");
        // W4: four zeros -> saturate, clear
        period(4, 1'b0, 1'b0, "R8");
        expect_alarm(1'b1, "R7 set after empty window");
        period(0, 1'b0, 1'b0, "R8");
        // W5: only unqualified zeros -> set
        period(6, 1'b1, 1'b0, "R5");
        expect_alarm(1'b0, "R8 four zeros clear without wrap");
        period(0, 1'b0, 1'b0, "R5");
        // W6: 1 + 1 zeros, plus a zero on the closing boundary -> clear
        period(1, 1'b0, 1'b0, "R6");
        expect_alarm(1'b1, "R5 unqualified zeros ignored");
        period(1, 1'b0, 1'b0, "R6");
        // W7: three zeros -> clear (closing zero of W6 on its first cycle)
        period(3, 1'b0, 1'b1, "R6");
        expect_alarm(1'b0, "R6 boundary-cycle zero closes window");
        period(0, 1'b0, 1'b0, "R9");
        // W8: two zeros -> set, no carry from W7
        period(2, 1'b0, 1'b0, "R9");
        expect_alarm(1'b0, "R9 three-zero window keeps clear");
        period(0, 1'b0, 1'b0, "R9");
        period(1, 1'b0, 1'b0, "R9");
        expect_alarm(1'b1, "R9 count restarted, two zeros set");
        // reset while alarm is high
        step(1'b1, 1'b1, 1'b1, 1'b0, "R1");
        expect_alarm(1'b0, "R1 reset clears alarm");
        // re-arm and check a fresh window after reset
        period(0, 1'b0, 1'b0, "R3");
        period(0, 1'b0, 1'b0, "R3");
        period(0, 1'b0, 1'b0, "R3");
        expect_alarm(1'b1, "R3 rearm after reset, empty window sets");
        step(1'b0, 1'b1, 1'b1, 1'b0, "R7");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule